// File: doc/BRIEF.md
# Scanline and Frame Timing Generator

This block turns a system clock into the line and frame events of a video raster. A fractional divider produces one scanline tick per programmed period. A line counter counts those ticks through one frame of either the 60 Hz standard (263 lines) or the 50 Hz standard (313 lines). The counter marks the first blanked line, and at the end of the frame it returns to zero and raises the frame interrupt. A second counter runs off the same ticks and issues an audio-service strobe once every 32 lines. It does not depend on frame boundaries.

The line period is given as an unsigned fixed-point number of clocks with FRAC_W fraction bits. It equals the clock rate divided by the product of frame rate and line total. A fractional remainder left at the end of a line is added to the next line, so the long-run line rate is exact. The standard select is taken while reset is held and again at each frame wrap, so a frame always runs to its full length in one standard.

Top module: `scan_frame_timer`

## Requirements
- R1: While reset is asserted, `line_num` is 0 and all three pulses are low. After release, the first line advance happens only after one full line period.
- R2: `clks_per_line` is unsigned fixed point with FRAC_W=4 fraction bits. After n clock edges since reset, the number of line advances is floor(n*16 / max(clks_per_line, 16)), so a fractional remainder carries into later lines.
- R3: A period value below 1.0 (below 16 in raw units) is treated as 1.0, which gives one line advance per clock.
- R4: With `region_sel`=0 (60 Hz), a frame is 263 lines, counting `line_num` 0 to 262 and then returning to 0.
- R5: With `region_sel`=1 (50 Hz), a frame is 313 lines, counting `line_num` 0 to 312 and then returning to 0. `line_num` never exceeds 312.
- R6: `vblank_start` is high for exactly one cycle when `line_num` becomes 240 (60 Hz) or 256 (50 Hz).
- R7: `frame_irq` is high for exactly one cycle when `line_num` wraps to 0 at the end of a frame.
- R8: `audio_strobe` is high for one cycle on every 32nd line advance. Its counter restarts after each strobe and runs freely across frame boundaries, so it can coincide with the other pulses.
- R9: `region_sel` takes effect only at reset and at a frame wrap. A change in mid-frame leaves the length of the running frame unchanged.
- R10: Each pulse is asserted in the same cycle in which `line_num` first shows the line that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| region_sel | input | 1 | Video standard: 0 = 60 Hz / 263 lines, 1 = 50 Hz / 313 lines |
| clks_per_line | input | INT_W+FRAC_W (20) | Line period in clocks, fixed point with 4 fraction bits |
| line_num | output | LINE_W (9) | Current scanline number |
| vblank_start | output | 1 | One-cycle pulse at the first blanked line |
| frame_irq | output | 1 | One-cycle pulse at frame wrap |
| audio_strobe | output | 1 | One-cycle pulse every 32 lines |

## Verification
The audio strobe is independent of the frame, so it can fall in the same cycle as either frame-level pulse. In the 50 Hz standard the blanking line 256 is also the eighth multiple of 32, so the first blanking pulse after reset lands together with a strobe. With one clock per line in the 60 Hz standard, the 32nd frame wrap after reset (line advance 8416) coincides with a strobe. Both runs are compared cycle by cycle against a bench model of all three pulses, and the bench also requires that at least one coincident cycle of each kind was seen.

// File: rtl/scan_timing_pkg.sv
package scan_timing_pkg;

    // Video standard held by the line sequencer for the current frame
    typedef enum logic {
        STD_60 = 1'b0,
        STD_50 = 1'b1
    } video_std_e;

endpackage

// File: rtl/scan_line_divider.sv
module scan_line_divider #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [INT_W+FRAC_W-1:0] period_i,
    output logic                    tick_o
);
    localparam int PER_W = INT_W + FRAC_W;
    localparam int ACC_W = PER_W + 1;
    localparam logic [ACC_W-1:0] ONE = ACC_W'(1) << FRAC_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [ACC_W-1:0] eff_period;
    logic [ACC_W-1:0] sum;

    // Phase accumulator: one unit per clock, a tick when a full period is reached,
    // the excess kept for the following line.
    always_comb begin
        eff_period = {1'b0, period_i};
        if (eff_period < ONE) begin
            eff_period = ONE;
        end
        sum    = st_q.acc + ONE;
        st_d   = st_q;
        tick_o = 1'b0;
        if (sum >= eff_period) begin
            tick_o     = 1'b1;
            st_d.acc   = sum - eff_period;
        end else begin
            st_d.acc   = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/scan_line_sequencer.sv
module scan_line_sequencer
    import scan_timing_pkg::*;
#(
    parameter int LINE_W    = 9,
    parameter int LINES_60  = 263,
    parameter int LINES_50  = 313,
    parameter int VBLANK_60 = 240,
    parameter int VBLANK_50 = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              region_i,
    output logic [LINE_W-1:0] line_o,
    output logic              vblank_o,
    output logic              frame_o
);
    typedef struct packed {
        logic [LINE_W-1:0] line;
        video_std_e        std;
        logic              vblank;
        logic              frame;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [LINE_W-1:0] nxt_line;
    logic [LINE_W-1:0] frame_total;
    logic [LINE_W-1:0] blank_line;

    always_comb begin
        frame_total = (st_q.std == STD_50) ? LINE_W'(LINES_50) : LINE_W'(LINES_60);
        blank_line  = (st_q.std == STD_50) ? LINE_W'(VBLANK_50) : LINE_W'(VBLANK_60);
        nxt_line    = st_q.line + LINE_W'(1);

        st_d        = st_q;
        st_d.vblank = 1'b0;
        st_d.frame  = 1'b0;

        if (tick_i) begin
            if (nxt_line == frame_total) begin
                // End of frame: wrap, interrupt, pick up the standard for the next frame
                st_d.line  = '0;
                st_d.frame = 1'b1;
                st_d.std   = video_std_e'(region_i);
            end else begin
                st_d.line   = nxt_line;
                st_d.vblank = (nxt_line == blank_line);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.line   <= '0;
            st_q.std    <= video_std_e'(region_i);
            st_q.vblank <= 1'b0;
            st_q.frame  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_o   = st_q.line;
    assign vblank_o = st_q.vblank;
    assign frame_o  = st_q.frame;

endmodule

// File: rtl/scan_audio_pacer.sv
module scan_audio_pacer #(
    parameter int LINES_PER_STROBE = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic strobe_o
);
    localparam int CNT_W = $clog2(LINES_PER_STROBE + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             strobe;
    } pace_state_t;

    pace_state_t st_d, st_q;
    logic [CNT_W-1:0] nxt_cnt;

    always_comb begin
        nxt_cnt     = st_q.cnt + CNT_W'(1);
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (tick_i) begin
            if (nxt_cnt == CNT_W'(LINES_PER_STROBE)) begin
                st_d.cnt    = '0;
                st_d.strobe = 1'b1;
            end else begin
                st_d.cnt    = nxt_cnt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_o = st_q.strobe;

endmodule

// File: rtl/scan_frame_timer.sv
module scan_frame_timer #(
    parameter int INT_W       = 16,
    parameter int FRAC_W      = 4,
    parameter int LINE_W      = 9,
    parameter int LINES_60    = 263,
    parameter int LINES_50    = 313,
    parameter int VBLANK_60   = 240,
    parameter int VBLANK_50   = 256,
    parameter int AUDIO_LINES = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    region_sel,
    input  logic [INT_W+FRAC_W-1:0] clks_per_line,
    output logic [LINE_W-1:0]       line_num,
    output logic                    vblank_start,
    output logic                    frame_irq,
    output logic                    audio_strobe
);
    logic line_tick;

    scan_line_divider #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (clks_per_line),
        .tick_o   (line_tick)
    );

    scan_line_sequencer #(
        .LINE_W    (LINE_W),
        .LINES_60  (LINES_60),
        .LINES_50  (LINES_50),
        .VBLANK_60 (VBLANK_60),
        .VBLANK_50 (VBLANK_50)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (line_tick),
        .region_i (region_sel),
        .line_o   (line_num),
        .vblank_o (vblank_start),
        .frame_o  (frame_irq)
    );

    scan_audio_pacer #(
        .LINES_PER_STROBE (AUDIO_LINES)
    ) u_aud (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (line_tick),
        .strobe_o (audio_strobe)
    );

endmodule

// File: rtl/scan_frame_timer_chk.sv
module scan_frame_timer_chk #(
    parameter int LINE_W    = 9,
    parameter int LINES_50  = 313,
    parameter int VBLANK_60 = 240,
    parameter int VBLANK_50 = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LINE_W-1:0] line_num,
    input logic              vblank_start,
    input logic              frame_irq,
    input logic              audio_strobe
);
    // R7
    frame_irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_irq |=> !frame_irq);

    // R8
    audio_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        audio_strobe |=> !audio_strobe);

    // R6
    vblank_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_start |-> (line_num == LINE_W'(VBLANK_60) || line_num == LINE_W'(VBLANK_50)));

    // R7
    frame_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_irq |-> (line_num == '0));

    // R4
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_num) |-> (line_num == $past(line_num) + LINE_W'(1) || (line_num == '0 && frame_irq)));

    // R5
    line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_num < LINE_W'(LINES_50));

    // R10
    irq_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_irq || vblank_start) |-> !$stable(line_num));

endmodule

bind scan_frame_timer scan_frame_timer_chk #(
    .LINE_W    (LINE_W),
    .LINES_50  (LINES_50),
    .VBLANK_60 (VBLANK_60),
    .VBLANK_50 (VBLANK_50)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_num     (line_num),
    .vblank_start (vblank_start),
    .frame_irq    (frame_irq),
    .audio_strobe (audio_strobe)
);

// File: tb/scan_frame_timer_test.sv
`timescale 1ns/1ps
module scan_frame_timer_test;
    localparam int ONE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        region_sel = 1'b0;
    logic [19:0] clks_per_line = 20'd64;
    logic [8:0]  line_num;
    logic        vblank_start, frame_irq, audio_strobe;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    int unsigned n_edges;
    longint      k_prev;
    int          m_line, m_aud, last_len, obs_lines, prev_obs;
    bit          m_std, seen_irq;
    int          both_fa, both_va;
    string       frame_tag;

    always #4 clk = ~clk;

    scan_frame_timer uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .region_sel    (region_sel),
        .clks_per_line (clks_per_line),
        .line_num      (line_num),
        .vblank_start  (vblank_start),
        .frame_irq     (frame_irq),
        .audio_strobe  (audio_strobe)
    );

    function automatic longint exp_ticks(int unsigned cyc, int unsigned per);
        longint eff = (per < ONE) ? ONE : per;
        return (longint'(cyc) * ONE) / eff;
    endfunction

    function automatic int frame_total(bit s);
        return s ? 313 : 263;
    endfunction

    function automatic int blank_line(bit s);
        return s ? 256 : 240;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic do_reset(logic [19:0] per, bit reg_v);
        @(negedge clk);
        clks_per_line = per;
        region_sel    = reg_v;
        rst_n         = 1'b0;
        #1;
        // R1 reset state
        check(line_num == 0, "R1", "line_num in reset", int'(line_num), 0);
        check({vblank_start, frame_irq, audio_strobe} == 3'b000, "R1", "pulses in reset",
              int'({vblank_start, frame_irq, audio_strobe}), 0);
        @(negedge clk);
        rst_n    = 1'b1;
        n_edges  = 0;
        k_prev   = 0;
        m_line   = 0;
        m_aud    = 0;
        m_std    = reg_v;
        obs_lines = 0;
        prev_obs = 0;
        seen_irq = 0;
        last_len = 0;
    endtask

    task automatic step_cycle();
        longint k;
        bit e_vb, e_fr, e_au;
        @(negedge clk);
        n_edges++;
        k = exp_ticks(n_edges, clks_per_line);
        e_vb = 0; e_fr = 0; e_au = 0;
        if (k != k_prev) begin
            k_prev = k;
            m_line++;
            if (m_line == frame_total(m_std)) begin
                last_len = frame_total(m_std);
                m_line = 0;
                e_fr = 1;
                m_std = region_sel;
            end else if (m_line == blank_line(m_std)) begin
                e_vb = 1;
            end
            m_aud++;
            if (m_aud == 32) begin
                m_aud = 0;
                e_au = 1;
            end
        end
        // R2 line position follows the fixed-point line rate
        check(int'(line_num) == m_line, "R2", "line_num", int'(line_num), m_line);
        // R6
        check(vblank_start == e_vb, "R6", "vblank_start", int'(vblank_start), int'(e_vb));
        // R7
        check(frame_irq == e_fr, "R7", "frame_irq", int'(frame_irq), int'(e_fr));
        // R8
        check(audio_strobe == e_au, "R8", "audio_strobe", int'(audio_strobe), int'(e_au));
        // R10 pulses coincide with the new line value
        if (vblank_start)
            check(line_num == 9'd240 || line_num == 9'd256, "R10", "line at vblank_start",
                  int'(line_num), blank_line(m_std));
        if (frame_irq)
            check(line_num == 0, "R10", "line at frame_irq", int'(line_num), 0);
        if (int'(line_num) != prev_obs) obs_lines++;
        prev_obs = int'(line_num);
        if (frame_irq) begin
            if (seen_irq)
                check(obs_lines == last_len, frame_tag, "lines per frame", obs_lines, last_len);
            seen_irq  = 1;
            obs_lines = 0;
        end
        if (frame_irq && audio_strobe) both_fa++;
        if (vblank_start && audio_strobe) both_va++;
    endtask

    task automatic run(int cycles);
        for (int i = 0; i < cycles; i++) step_cycle();
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        both_fa = 0;
        both_va = 0;

        // R1 / R4: 60 Hz, 4.0 clocks per line
        frame_tag = "R4";
        do_reset(20'd64, 1'b0);
        run(3);
        check(line_num == 0, "R1", "no advance before full period", int'(line_num), 0);
        run(1);
        check(line_num == 1, "R1", "first advance after full period", int'(line_num), 1);
        run(4 * 2 * 263 + 40);

        // R5 / R8: 50 Hz, 2.0 clocks per line; line 256 meets a strobe
        frame_tag = "R5";
        do_reset(20'd32, 1'b1);
        run(2 * 2 * 313 + 20);
        check(both_va >= 1, "R8", "vblank_start with audio_strobe seen", both_va, 1);

        // R2: fractional period 3.25 clocks
        frame_tag = "R4";
        do_reset(20'd52, 1'b0);
        run(2600);
        check(k_prev == exp_ticks(n_edges, 52), "R2", "fractional line count",
              int'(k_prev), int'(exp_ticks(n_edges, 52)));

        // R3: period below 1.0 acts as 1.0
        do_reset(20'd8, 1'b0);
        run(100);
        check(line_num == 100, "R3", "one line per clock", int'(line_num), 100);
        run(300);

        // R9: standard change in mid-frame
        frame_tag = "R9";
        do_reset(20'd16, 1'b0);
        run(100);
        region_sel = 1'b1;
        run(163);
        check(frame_irq == 1'b1, "R9", "frame ends at 263 after mid-frame change",
              int'(frame_irq), 1);
        run(313);
        check(frame_irq == 1'b1, "R9", "next frame is 313 lines", int'(frame_irq), 1);
        region_sel = 1'b0;
        run(400);

        // R8: frame wrap coinciding with audio strobe (32 frames at 1 clock/line)
        frame_tag = "R4";
        do_reset(20'd16, 1'b0);
        run(8420);
        check(both_fa >= 1, "R8", "frame_irq with audio_strobe seen", both_fa, 1);

        // Random periods and region flips
        frame_tag = "R9";
        for (int ph = 0; ph < 6; ph++) begin
            logic [19:0] per;
            per = 20'(($urandom % 6 + 1) * ONE + ($urandom % ONE));
            do_reset(per, 1'($urandom % 2));
            for (int s = 0; s < 6; s++) begin
                run(300 + int'($urandom % 400));
                region_sel = 1'($urandom % 2);
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #1592000;
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule